// File: doc/BRIEF.md
# Selectable IR Carrier Generator

This block drives the transmit pin of an infrared remote-control transmitter. A 3-bit select register chooses how the system clock is divided and what fraction of each period the output is on. The choices are periods of 12, 8 or 11 clocks with several duty cycles, or a plain level with no carrier. A single port-data bit gates the carrier. While the bit is high the selected waveform appears on the pin. While it is low the pin stays inactive.

Software writes the select code first and then raises the data bit. A rising data bit restarts the divide counter at zero and latches the select code, so the first pulse always has full width. A select write made while the carrier is running is held back until the current period ends. In stop mode the pin is released to high impedance.

The output is a drive enable for an open-drain transistor, where 1 pulls the LED on, together with a high-impedance control.

Top module: `ir_carrier_gen`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `drv_en` is 0. The stored select code and the latched code both reset to 000.
- R2: Code 000 gives a period of 12 clocks. `drv_en` is 1 for the first 6 phases of each period.
- R3: Code 001 gives a period of 12 with 4 high phases. Code 010 gives a period of 12 with 3 high phases.
- R4: Code 011 gives a period of 8 with 4 high phases. Code 100 gives a period of 8 with 2 high phases.
- R5: Code 101 gives a period of 11 with 4 high phases.
- R6: Codes 110 and 111 select no carrier. `drv_en` then equals the data bit registered one clock earlier.
- R7: When `data_bit` was 0 at the previous clock edge, `drv_en` is 0 for every code.
- R8: A clock edge that samples `data_bit` high after it was low restarts the phase at 0. The next cycle is therefore the first cycle of a full-width high time.
- R9: A select write while the carrier runs leaves the current period unchanged. The new code governs the period that starts at the next boundary.
- R10: While `stop_mode` is 1, `pin_hiz` is 1 and `drv_en` is 0 in the same cycle. While `stop_mode` is 0, `pin_hiz` is 0.
- R11: The carrier uses the code stored at the edge where the data bit rises. A code written any number of cycles earlier, while the data bit was low, applies from the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_we | input | 1 | Write strobe for the select code |
| sel_wdata | input | 3 | Select code to store |
| data_bit | input | 1 | Port data bit that gates the carrier |
| stop_mode | input | 1 | Stop-mode flag |
| drv_en | output | 1 | Open-drain drive enable (1 = LED on) |
| pin_hiz | output | 1 | High-impedance control for the pin |

## Verification
The assertions assume that `stop_mode` is a level that releases the pin as soon as it is set. They also assume that `data_bit` and `sel_wdata` are stable across each clock edge. The bench meets both conditions by changing every input shortly after a rising edge, never near one. The bench raises `data_bit` only after a select write has completed, except in the one case that changes the code while the carrier is running. That case is placed at a known phase, so the boundary behaviour is exercised without ambiguity.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

    localparam int SEL_W = 3;
    localparam int PH_W  = 4;

    typedef struct packed {
        logic [PH_W-1:0] period;
        logic [PH_W-1:0] high;
        logic            carrier;
    } mode_cfg_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [SEL_W-1:0] act;
        logic             data;
    } ctl_state_t;

    function automatic mode_cfg_t decode_mode(input logic [SEL_W-1:0] code);
        mode_cfg_t cfg;
        unique case (code)
            3'd0:    cfg = '{period: PH_W'(12), high: PH_W'(6), carrier: 1'b1};
            3'd1:    cfg = '{period: PH_W'(12), high: PH_W'(4), carrier: 1'b1};
            3'd2:    cfg = '{period: PH_W'(12), high: PH_W'(3), carrier: 1'b1};
            3'd3:    cfg = '{period: PH_W'(8),  high: PH_W'(4), carrier: 1'b1};
            3'd4:    cfg = '{period: PH_W'(8),  high: PH_W'(2), carrier: 1'b1};
            3'd5:    cfg = '{period: PH_W'(11), high: PH_W'(4), carrier: 1'b1};
            default: cfg = '{period: PH_W'(12), high: PH_W'(0), carrier: 1'b0};
        endcase
        return cfg;
    endfunction

endpackage

// File: rtl/ir_mode_decode.sv
module ir_mode_decode
    import ir_carrier_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    output mode_cfg_t        cfg
);
    always_comb begin
        cfg = decode_mode(code);
    end
endmodule

// File: rtl/ir_phase_ctr.sv
module ir_phase_ctr #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            restart,
    input  logic [PH_W-1:0] period,
    output logic [PH_W-1:0] ph_q,
    output logic            wrap
);
    logic [PH_W-1:0] ph_d;
    logic            at_end;

    always_comb begin
        at_end = (ph_q == period - 1'b1);
        wrap   = run && !restart && at_end;
        ph_d   = ph_q;
        if (restart) begin
            ph_d = '0;
        end else if (run) begin
            ph_d = at_end ? '0 : ph_q + 1'b1;
        end else begin
            ph_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end
endmodule

// File: rtl/ir_out_stage.sv
module ir_out_stage
    import ir_carrier_pkg::*;
(
    input  logic            data_q,
    input  logic            stop_mode,
    input  logic [PH_W-1:0] ph,
    input  mode_cfg_t       cfg,
    output logic            drv_en,
    output logic            pin_hiz
);
    logic on_phase;

    always_comb begin
        on_phase = cfg.carrier ? (ph < cfg.high) : 1'b1;
        drv_en   = !stop_mode && data_q && on_phase;
        pin_hiz  = stop_mode;
    end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ir_carrier_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             data_bit,
    input  logic             stop_mode,
    output logic             drv_en,
    output logic             pin_hiz
);
    ctl_state_t      st_d, st_q;
    mode_cfg_t       act_cfg;
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] act_period;
    logic            data_q;
    logic            rise;
    logic            run;
    logic            wrap;

    assign data_q     = st_q.data;
    assign act_period = act_cfg.period;

    always_comb begin
        rise = data_bit && !st_q.data;
        run  = data_bit && st_q.data;
        st_d = st_q;
        if (sel_we) begin
            st_d.sel = sel_wdata;
        end
        if (rise || wrap) begin
            st_d.act = st_q.sel;
        end
        st_d.data = data_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ir_mode_decode i_dec (
        .code (st_q.act),
        .cfg  (act_cfg)
    );

    ir_phase_ctr #(.PH_W(PH_W)) i_ctr (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (rise),
        .period  (act_cfg.period),
        .ph_q    (ph_q),
        .wrap    (wrap)
    );

    ir_out_stage i_out (
        .data_q    (st_q.data),
        .stop_mode (stop_mode),
        .ph        (ph_q),
        .cfg       (act_cfg),
        .drv_en    (drv_en),
        .pin_hiz   (pin_hiz)
    );
endmodule

// File: rtl/ir_carrier_chk.sv
module ir_carrier_chk
    import ir_carrier_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            data_bit,
    input logic            stop_mode,
    input logic            drv_en,
    input logic            pin_hiz,
    input logic            data_q,
    input logic [PH_W-1:0] ph,
    input logic [PH_W-1:0] period
);
    logic armed_q;

    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !drv_en);

    // R10
    stop_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        stop_mode |-> (pin_hiz && !drv_en));

    // R7
    data_low_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !$past(data_bit)) |-> !drv_en);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $rose(data_q)) |-> (ph == '0));

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        ph < period);
endmodule

bind ir_carrier_gen ir_carrier_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .data_bit  (data_bit),
    .stop_mode (stop_mode),
    .drv_en    (drv_en),
    .pin_hiz   (pin_hiz),
    .data_q    (data_q),
    .ph        (ph_q),
    .period    (act_period)
);

// File: tb/test_ir_carrier_gen.sv
module test_ir_carrier_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_we = 1'b0;
    logic [2:0] sel_wdata = 3'd0;
    logic       data_bit = 1'b0;
    logic       stop_mode = 1'b0;
    logic       drv_en;
    logic       pin_hiz;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int m_sel = 0, m_act = 0, m_ph = 0;
    bit m_data = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_carrier_gen i_ir_carrier_gen (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .data_bit(data_bit), .stop_mode(stop_mode),
        .drv_en(drv_en), .pin_hiz(pin_hiz)
    );

    function automatic int f_per(int c);
        if (c == 3 || c == 4) return 8;
        if (c == 5) return 11;
        return 12;
    endfunction

    function automatic int f_high(int c);
        case (c)
            0: return 6;
            1: return 4;
            2: return 3;
            3: return 4;
            4: return 2;
            5: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic string f_tag(int c);
        if (c == 0) return "R2";
        if (c <= 2) return "R3";
        if (c <= 4) return "R4";
        if (c == 5) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int old_sel;
        old_sel = m_sel;
        if (rst) begin
            m_sel = 0; m_act = 0; m_ph = 0; m_data = 0;
        end else begin
            if (sel_we) m_sel = sel_wdata;
            if (data_bit && !m_data) begin
                m_ph = 0; m_act = old_sel;
            end else if (data_bit && m_data) begin
                if (m_ph == f_per(m_act) - 1) begin
                    m_ph = 0; m_act = old_sel;
                end else begin
                    m_ph++;
                end
            end else begin
                m_ph = 0;
            end
            m_data = data_bit;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int exp;
            if (stop_mode || !m_data) exp = 0;
            else if (m_act >= 6) exp = 1;
            else exp = (m_ph < f_high(m_act)) ? 1 : 0;
            check(f_tag(m_act), drv_en, exp, "model drv_en");
            check("R10", pin_hiz, stop_mode, "model pin_hiz");
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic measure(input int code, input string tag);
        int cnt;
        int per;
        int hi;
        per = f_per(code);
        hi  = (code >= 6) ? per : f_high(code);
        step(); sel_we = 1'b1; sel_wdata = 3'(code);
        step(); sel_we = 1'b0;
        repeat (3) step();
        data_bit = 1'b1;
        @(negedge clk);
        check("R7", drv_en, 0, "before rise");
        cnt = 0;
        for (int i = 0; i < 2*per; i++) begin
            @(negedge clk);
            if (i == 0) check("R8", drv_en, 1, "first phase high");
            cnt += int'(drv_en);
            if (i == per - 1) check("R8", cnt, hi, "first period full width");
        end
        check(tag, cnt, 2*hi, "high count over two periods");
        check("R11", cnt, 2*hi, "preset code used from start");
        step(); data_bit = 1'b0;
        step(); step();
    endtask

    initial begin
        repeat (3) step();
        @(negedge clk);
        check("R1", drv_en, 0, "drv_en in reset");
        step(); rst = 1'b0;
        @(negedge clk);
        check("R1", drv_en, 0, "drv_en after reset");
        check("R1", pin_hiz, 0, "pin_hiz after reset");

        // data low, default code: no output
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R7", drv_en, 0, "data low");
        end

        measure(0, "R2");
        measure(1, "R3");
        measure(2, "R3");
        measure(3, "R4");
        measure(4, "R4");
        measure(5, "R5");
        measure(6, "R6");
        measure(7, "R6");

        // R9: change code mid-period
        step(); sel_we = 1'b1; sel_wdata = 3'd0;
        step(); sel_we = 1'b0; data_bit = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (i == 3) begin
                #1 sel_we = 1'b1; sel_wdata = 3'd3;
            end
            if (i == 4) sel_we = 1'b0;
            if (i >= 6 && i <= 11) check("R9", drv_en, 0, "old period tail");
            if (i == 12) check("R9", drv_en, 1, "new period start");
            if (i == 16) check("R9", drv_en, 0, "new period off at 4");
            if (i == 20) check("R9", drv_en, 1, "new period of 8");
        end

        // R10: stop mode while carrier runs
        step(); stop_mode = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R10", pin_hiz, 1, "hiz in stop");
            check("R10", drv_en, 0, "no drive in stop");
        end
        step(); stop_mode = 1'b0; data_bit = 1'b0;
        step(); step();
        @(negedge clk);
        check("R10", pin_hiz, 0, "hiz released");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule